// File: doc/BRIEF.md
# SD Host Block Data Buffer Port

This block is the data path of an SD host controller between the host register bus and the card. Software programs a block size and a block count in one geometry word. The command path then hands the block a start strobe and a six-bit command index. The index selects the transfer direction and whether one block or several move. Four indices are recognised: 17, 18, 24 and 25. Every other index is ignored.

For writes, the block announces an empty buffer through an interrupt status strobe. The host then pushes 32-bit words into the data port. Each full block is shifted out to the card one byte at a time. For reads, bytes arrive from the card into the same buffer. A strobe announces the full block, and the host pulls it out through the data port in 32-bit words. The card side is a pair of byte-wide valid/ready streams. The line coding and CRC of the card bus belong to other logic.

Interrupt status events leave the block as one-cycle set strobes at their normal status bit positions, ready for the interrupt logic to latch. The block count in the geometry word counts down as a multi-block transfer proceeds.

Top module: `sdbuf_port`

## Requirements
- R1: Synchronous active-high reset leaves the block idle. After reset `xfer_active`, `int_set`, `card_tx_valid` and `card_rx_ready` are 0, and the geometry word reads 0.
- R2: Address 0x04 holds the geometry word: bits 15:0 are the block size and bits 31:16 are the block count. It can be written only while no transfer is active; writes during a transfer leave it unchanged.
- R3: A start strobe is accepted only while idle. Index 17 starts a one-block read, 18 a multi-block read, 24 a one-block write and 25 a multi-block write. Any other index is ignored. A start is also ignored when the effective size is 0, or when the index is multi-block and the count is 0.
- R4: The effective block size is size bits 11:0, limited to at most the buffer depth of 512 bytes.
- R5: A write sets `int_set` bit 4 for one cycle after the accepting edge, and again after each block except the last has gone to the card. Each write to the data port at 0x20 stores four bytes, bits 7:0 first. Once the effective size is reached, the block goes out on the transmit stream in byte order. Bytes past the size in the final word are dropped.
- R6: A transmit byte moves on a cycle with `card_tx_valid` and `card_tx_ready` both high. While ready is low, valid and data hold.
- R7: A read takes receive bytes while `card_rx_ready` is high. After a full block, `int_set` bit 5 pulses for one cycle. Each read of the data port returns the next four bytes, bits 7:0 first. Byte lanes past the effective size read 0.
- R8: A multi-block transfer runs for the programmed count, and the count drops by one after each block. A one-block transfer moves exactly one block and leaves the count unchanged.
- R9: After the last block, `int_set` bit 1 pulses for one cycle, and `xfer_active` falls on the same edge.
- R10: Data port accesses in the wrong phase are ignored. Reads outside the host-drain phase return 0 and do not advance. Writes outside the host-fill phase store nothing.
- R11: At most one `int_set` bit is high in any cycle, and only bits 1, 4 and 5 are ever used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data port) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| cmd_start | input | 1 | Command issued strobe |
| cmd_index | input | 6 | Index of the issued command |
| card_rx_valid | input | 1 | Receive byte from card valid |
| card_rx_data | input | 8 | Receive byte from card |
| card_rx_ready | output | 1 | Block accepts a receive byte |
| card_tx_valid | output | 1 | Transmit byte to card valid |
| card_tx_data | output | 8 | Transmit byte to card |
| card_tx_ready | input | 1 | Card accepts a transmit byte |
| int_set | output | 16 | One-cycle normal interrupt status set strobes |
| xfer_active | output | 1 | A data transfer is in progress |

## Verification
Two events can meet in one cycle: the final transmit handshake of the last block, and a new start strobe from the command path. The bench raises `cmd_start` with a valid read index in exactly the cycle the last byte is taken. It then expects the completion strobe alone, with `xfer_active` low. In the following cycle it expects the block still idle with no strobes, which shows the late command was dropped and did not start a transfer. The sweeps also cover sizes 1 to 8 in both directions, so partial final words on both the port write and the port read paths meet block boundaries.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;

    localparam int unsigned PORT_LANES = 4;
    localparam int unsigned GEOM_W     = 16;

    localparam logic [7:0] OFF_GEOM = 8'h04;
    localparam logic [7:0] OFF_PORT = 8'h20;

    localparam logic [5:0] IDX_RD_ONE  = 6'd17;
    localparam logic [5:0] IDX_RD_MANY = 6'd18;
    localparam logic [5:0] IDX_WR_ONE  = 6'd24;
    localparam logic [5:0] IDX_WR_MANY = 6'd25;

    localparam int unsigned EV_DONE     = 1;
    localparam int unsigned EV_WR_READY = 4;
    localparam int unsigned EV_RD_READY = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOST_FILL,
        PH_CARD_DRAIN,
        PH_CARD_FILL,
        PH_HOST_DRAIN
    } phase_t;

    typedef struct packed {
        logic ok;
        logic wr;
        logic multi;
    } cmd_kind_t;

    function automatic cmd_kind_t decode_cmd(input logic [5:0] idx);
        cmd_kind_t k;
        k = '0;
        case (idx)
            IDX_RD_ONE:  k.ok = 1'b1;
            IDX_RD_MANY: begin k.ok = 1'b1; k.multi = 1'b1; end
            IDX_WR_ONE:  begin k.ok = 1'b1; k.wr = 1'b1; end
            IDX_WR_MANY: begin k.ok = 1'b1; k.wr = 1'b1; k.multi = 1'b1; end
            default:     k = '0;
        endcase
        return k;
    endfunction

    function automatic logic [15:0] eff_size(input logic [15:0] raw, input logic [15:0] cap);
        logic [15:0] low;
        low = {4'b0000, raw[11:0]};
        return (low > cap) ? cap : low;
    endfunction

endpackage

// File: rtl/sdbuf_geom.sv
module sdbuf_geom #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [2*W-1:0] wdata,
    input  logic           dec,
    output logic [W-1:0]   size_q,
    output logic [W-1:0]   count_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            size_q  <= '0;
            count_q <= '0;
        end else if (wr_en) begin
            size_q  <= wdata[W-1:0];
            count_q <= wdata[2*W-1:W];
        end else if (dec) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/sdbuf_mem.sv
module sdbuf_mem #(
    parameter int DEPTH = 512,
    parameter int LANES = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wide_we,
    input  logic [LANES*8-1:0] wide_wdata,
    input  logic               byte_we,
    input  logic [7:0]         byte_wdata,
    input  logic [AW-1:0]      addr,
    output logic [LANES*8-1:0] wide_rdata,
    output logic [7:0]         byte_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wide_we) begin
            for (int i = 0; i < LANES; i++)
                mem[addr + AW'(i)] <= wide_wdata[i*8 +: 8];
        end else if (byte_we) begin
            mem[addr] <= byte_wdata;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wide_rdata[g*8 +: 8] = mem[addr + AW'(g)];
    end

    assign byte_rdata = mem[addr];
endmodule

// File: rtl/sdbuf_port.sv
module sdbuf_port
    import sdbuf_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cmd_start,
    input  logic [5:0]        cmd_index,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_data,
    input  logic              card_tx_ready,
    output logic [15:0]       int_set,
    output logic              xfer_active
);
    localparam int AW    = $clog2(BUF_BYTES);
    localparam int SZ_W  = AW + 1;
    localparam int LANES = PORT_LANES;

    phase_t                 phase;
    logic [SZ_W-1:0]        ptr, bsize;
    logic [GEOM_W-1:0]      left;
    logic                   is_wr, is_multi;
    logic [15:0]            int_set_q;
    logic [GEOM_W-1:0]      g_size, g_count;
    logic [15:0]            eff;
    cmd_kind_t              kind;
    logic                   start_ok, port_hit, host_wr_go, host_rd_go, tx_go, rx_go;
    logic                   word_last, byte_last, blk_end, geom_we;
    logic [LANES*8-1:0]     wide_rdata, drain_word;
    logic [7:0]             byte_rdata;

    assign kind       = decode_cmd(cmd_index);
    assign eff        = eff_size(g_size, 16'(BUF_BYTES));
    assign start_ok   = cmd_start && (phase == PH_IDLE) && kind.ok && (eff != 16'd0)
                        && (!kind.multi || (g_count != '0));
    assign port_hit   = (bus_addr == ADDR_W'(OFF_PORT));
    assign host_wr_go = (phase == PH_HOST_FILL) && bus_wr && port_hit;
    assign host_rd_go = (phase == PH_HOST_DRAIN) && bus_rd && port_hit;
    assign tx_go      = (phase == PH_CARD_DRAIN) && card_tx_ready;
    assign rx_go      = (phase == PH_CARD_FILL) && card_rx_valid;
    assign word_last  = ({1'b0, ptr} + (SZ_W+1)'(LANES)) >= {1'b0, bsize};
    assign byte_last  = (ptr == bsize - 1'b1);
    assign blk_end    = (tx_go && byte_last) || (host_rd_go && word_last);
    assign geom_we    = bus_wr && (bus_addr == ADDR_W'(OFF_GEOM)) && (phase == PH_IDLE);

    sdbuf_geom #(.W(GEOM_W)) u_geom (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (geom_we),
        .wdata   (bus_wdata),
        .dec     (blk_end && is_multi),
        .size_q  (g_size),
        .count_q (g_count)
    );

    sdbuf_mem #(.DEPTH(BUF_BYTES), .LANES(LANES)) u_mem (
        .clk        (clk),
        .wide_we    (host_wr_go),
        .wide_wdata (bus_wdata),
        .byte_we    (rx_go),
        .byte_wdata (card_rx_data),
        .addr       (ptr[AW-1:0]),
        .wide_rdata (wide_rdata),
        .byte_rdata (byte_rdata)
    );

    // Lanes past the block size read as zero on the host side.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (({1'b0, ptr} + (SZ_W+1)'(i)) < {1'b0, bsize})
                drain_word[i*8 +: 8] = wide_rdata[i*8 +: 8];
            else
                drain_word[i*8 +: 8] = 8'h00;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_GEOM))
            bus_rdata = {g_count, g_size};
        else if (port_hit && (phase == PH_HOST_DRAIN))
            bus_rdata = drain_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            ptr       <= '0;
            bsize     <= '0;
            left      <= '0;
            is_wr     <= 1'b0;
            is_multi  <= 1'b0;
            int_set_q <= '0;
        end else begin
            int_set_q <= '0;
            unique case (phase)
                PH_IDLE: if (start_ok) begin
                    ptr      <= '0;
                    bsize    <= SZ_W'(eff);
                    left     <= kind.multi ? g_count : GEOM_W'(1);
                    is_wr    <= kind.wr;
                    is_multi <= kind.multi;
                    phase    <= kind.wr ? PH_HOST_FILL : PH_CARD_FILL;
                    if (kind.wr) int_set_q[EV_WR_READY] <= 1'b1;
                end
                PH_HOST_FILL: if (host_wr_go) begin
                    if (word_last) begin
                        phase <= PH_CARD_DRAIN;
                        ptr   <= '0;
                    end else begin
                        ptr <= ptr + SZ_W'(LANES);
                    end
                end
                PH_CARD_DRAIN: if (tx_go && !byte_last) ptr <= ptr + 1'b1;
                PH_CARD_FILL: if (rx_go) begin
                    if (byte_last) begin
                        phase <= PH_HOST_DRAIN;
                        ptr   <= '0;
                        int_set_q[EV_RD_READY] <= 1'b1;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                PH_HOST_DRAIN: if (host_rd_go && !word_last) ptr <= ptr + SZ_W'(LANES);
                default: phase <= PH_IDLE;
            endcase
            if (blk_end) begin
                ptr <= '0;
                if (left == GEOM_W'(1)) begin
                    phase <= PH_IDLE;
                    int_set_q[EV_DONE] <= 1'b1;
                end else begin
                    left <= left - 1'b1;
                    if (is_wr) begin
                        phase <= PH_HOST_FILL;
                        int_set_q[EV_WR_READY] <= 1'b1;
                    end else begin
                        phase <= PH_CARD_FILL;
                    end
                end
            end
        end
    end

    assign card_tx_valid = (phase == PH_CARD_DRAIN);
    assign card_tx_data  = byte_rdata;
    assign card_rx_ready = (phase == PH_CARD_FILL);
    assign xfer_active   = (phase != PH_IDLE);
    assign int_set       = int_set_q;
endmodule

// File: rtl/sdbuf_port_chk.sv
module sdbuf_port_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] int_set,
    input logic        xfer_active,
    input logic        card_tx_valid,
    input logic        card_tx_ready,
    input logic [7:0]  card_tx_data,
    input logic        card_rx_ready,
    input logic [15:0] g_size,
    input logic [15:0] g_count
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |-> (!card_tx_valid && !card_rx_ready));

    assert_geom_locked_R2: assert property (@(posedge clk) disable iff (rst)
        xfer_active |=> $stable(g_size));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (card_tx_valid && !card_tx_ready) |=> (card_tx_valid && $stable(card_tx_data)));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_active |=> (g_count == $past(g_count) || g_count == $past(g_count) - 16'd1));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        int_set[1] |-> !xfer_active);

    assert_one_event_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_set) && ((int_set & 16'hFFCD) == 16'h0000));

    assert_one_stream_R10: assert property (@(posedge clk) disable iff (rst)
        !(card_tx_valid && card_rx_ready));
endmodule

bind sdbuf_port sdbuf_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .int_set       (int_set),
    .xfer_active   (xfer_active),
    .card_tx_valid (card_tx_valid),
    .card_tx_ready (card_tx_ready),
    .card_tx_data  (card_tx_data),
    .card_rx_ready (card_rx_ready),
    .g_size        (g_size),
    .g_count       (g_count)
);

// File: tb/sdbuf_port_test.sv
module sdbuf_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic [15:0] int_set;
    logic        xfer_active;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdbuf_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_start(cmd_start),
        .cmd_index(cmd_index), .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .int_set(int_set), .xfer_active(xfer_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int seed, input int blk, input int idx);
        return 8'(seed * 29 + blk * 71 + idx * 3 + 1);
    endfunction

    function automatic int eff_of(input logic [15:0] raw);
        return (raw[11:0] > 12'd512) ? 512 : int'(raw[11:0]);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic read_geom(output logic [31:0] v);
        bus_addr = 8'h04;
        #1;
        v = bus_rdata;
    endtask

    task automatic issue(input logic [5:0] idx);
        cmd_index = idx; cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    task automatic run_write(input logic [15:0] raw, input int cnt, input bit multi,
                             input int seed, input bit extra, input bit clash);
        int eff, nblk, got, cyc;
        logic [31:0] g;
        eff  = eff_of(raw);
        nblk = multi ? cnt : 1;
        bus_write(8'h04, {16'(cnt), raw});
        issue(multi ? 6'd25 : 6'd24);
        check(xfer_active && int_set == 16'h0010, "R5", "write start ready", int_set, 16'h0010);
        for (int b = 0; b < nblk; b++) begin
            if (b == 0) begin
                bus_addr = 8'h20; bus_rd = 1'b1;
                #1;
                check(bus_rdata == 32'h0, "R10", "port read during host fill", bus_rdata, 0);
                tick();
                bus_rd = 1'b0;
            end
            if (extra && b == 0) begin
                bus_write(8'h04, 32'h0009_0007);
                read_geom(g);
                check(g == {16'(cnt), raw}, "R2", "geometry write while active", g, {16'(cnt), raw});
                issue(6'd17);
                check(xfer_active && !card_rx_ready, "R3", "start while active", card_rx_ready, 0);
            end
            for (int w = 0; w < (eff + 3) / 4; w++) begin
                logic [31:0] d;
                for (int l = 0; l < 4; l++) d[l*8 +: 8] = pat(seed, b, w * 4 + l);
                bus_write(8'h20, d);
            end
            got = 0; cyc = 0;
            while (got < eff && cyc < 4000) begin
                card_tx_ready = ((cyc + seed) % 3 != 0);
                #1;
                if (card_tx_valid && card_tx_ready) begin
                    check(card_tx_data == pat(seed, b, got), "R5", "tx byte", card_tx_data, pat(seed, b, got));
                    if (clash && b == nblk - 1 && got == eff - 1) begin
                        cmd_index = 6'd17; cmd_start = 1'b1;
                    end
                    got++;
                end
                tick();
                cmd_start = 1'b0;
                cyc++;
            end
            card_tx_ready = 1'b0;
            check(got == eff, "R6", "tx byte count", got, eff);
            read_geom(g);
            check(g[31:16] == 16'(multi ? cnt - b - 1 : cnt), "R8", "count after write block",
                  g[31:16], multi ? cnt - b - 1 : cnt);
            if (b == nblk - 1)
                check(!xfer_active && int_set == 16'h0002, "R9", "write done", int_set, 16'h0002);
            else
                check(xfer_active && int_set == 16'h0010, "R5", "next write ready", int_set, 16'h0010);
        end
        tick();
        check(!xfer_active && int_set == 16'h0, "R3", "idle after done", {xfer_active, int_set}, 0);
    endtask

    task automatic run_read(input logic [15:0] raw, input int cnt, input bit multi,
                            input int seed, input bit stray);
        int eff, nblk, got, cyc;
        logic [31:0] g, exp;
        eff  = eff_of(raw);
        nblk = multi ? cnt : 1;
        bus_write(8'h04, {16'(cnt), raw});
        issue(multi ? 6'd18 : 6'd17);
        check(xfer_active && card_rx_ready && int_set == 16'h0, "R7", "read start", int_set, 0);
        for (int b = 0; b < nblk; b++) begin
            got = 0; cyc = 0;
            while (got < eff && cyc < 4000) begin
                card_rx_valid = ((cyc + seed) % 4 != 2);
                card_rx_data  = pat(seed, b, got);
                if (stray && cyc == 0) begin
                    bus_addr = 8'h20; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1;
                end
                #1;
                if (card_rx_valid && card_rx_ready) got++;
                tick();
                bus_wr = 1'b0;
                cyc++;
            end
            card_rx_valid = 1'b0;
            check(int_set == 16'h0020, "R7", "read block ready", int_set, 16'h0020);
            if (stray) bus_write(8'h20, 32'hA5A5_A5A5);
            for (int w = 0; w < (eff + 3) / 4; w++) begin
                for (int l = 0; l < 4; l++)
                    exp[l*8 +: 8] = (w * 4 + l < eff) ? pat(seed, b, w * 4 + l) : 8'h00;
                bus_addr = 8'h20; bus_rd = 1'b1;
                #1;
                check(bus_rdata == exp, stray ? "R10" : "R7", "port read word", bus_rdata, exp);
                tick();
                bus_rd = 1'b0;
            end
            read_geom(g);
            check(g[31:16] == 16'(multi ? cnt - b - 1 : cnt), "R8", "count after read block",
                  g[31:16], multi ? cnt - b - 1 : cnt);
            if (b == nblk - 1) begin
                check(!xfer_active && int_set == 16'h0002, "R9", "read done", int_set, 16'h0002);
                bus_addr = 8'h20;
                #1;
                check(bus_rdata == 32'h0, "R10", "port read when idle", bus_rdata, 0);
            end else begin
                check(xfer_active && card_rx_ready && int_set == 16'h0, "R7", "next read block", int_set, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] g;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        read_geom(g);
        check(!xfer_active && int_set == 0 && !card_tx_valid && !card_rx_ready && g == 0,
              "R1", "reset state", {xfer_active, int_set, g}, 0);
        bus_write(8'h04, 32'h0001_0004);
        issue(6'd12);
        check(!xfer_active, "R3", "unknown index ignored", xfer_active, 0);
        bus_write(8'h04, 32'h0001_0000);
        issue(6'd24);
        check(!xfer_active, "R3", "zero size ignored", xfer_active, 0);
        bus_write(8'h04, 32'h0000_0008);
        issue(6'd25);
        check(!xfer_active, "R3", "multi with zero count ignored", xfer_active, 0);
        bus_write(8'h04, 32'h0000_7000);
        issue(6'd17);
        check(!xfer_active, "R4", "size bits above 11 ignored", xfer_active, 0);

        for (int s = 1; s <= 8; s++) begin
            run_write(16'(s), 2, 1'b1, s, s == 3, s == 5);
            run_write(16'(s), 3, 1'b0, s + 20, 1'b0, 1'b0);
            run_read(16'(s), 2, 1'b1, s + 40, s == 2);
            run_read(16'(s), 3, 1'b0, s + 60, 1'b0);
        end
        run_read(16'hF005, 1, 1'b1, 7, 1'b0);   // R4: only bits 11:0 -> 5 bytes
        run_write(16'h1FFF, 1, 1'b0, 9, 1'b0, 1'b0); // R4: capped at 512
        run_read(16'h0300, 2, 1'b1, 11, 1'b0);  // R4: 768 capped at 512
        run_write(16'h0200, 2, 1'b1, 13, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule